// File: doc/BRIEF.md
# Serial receive status and data register block

This block sits between the byte assembler of a serial receiver and a CPU read port. Each completed byte arrives with a one-cycle strobe and a per-byte noise indication. The block holds the byte in a data register and keeps three status flags: byte available, overrun and noise. It drives an interrupt request from those flags and three enable inputs.

Software clears flags with a two-step sequence: it reads status, then reads data. A status read takes a snapshot of the flags and arms the clear. The next data read clears only the flags that were in that snapshot. A flag that rises between the two reads survives the data read. Software therefore reads status a second time to learn whether a byte was lost during the sequence. When a byte completes while the previous one is still unread, the unread byte stays in the data register and the new byte is dropped.

Top module: `rx_flag_ctrl`

## Requirements
- R1: After reset the status register reads 0, the data register reads 0 and irq_o is low.
- R2: A byte strobe while the full flag is clear loads the byte into the data register and sets the full flag (status bit 0).
- R3: A data read that follows a status read returns the held byte and clears every flag that was set at that status read.
- R4: A data read with no status read since the last data read clears no flag. It still returns the held byte.
- R5: A flag that was clear at the status read and is set before the following data read stays set after that data read.
- R6: A byte strobe while the full flag is set and not being cleared sets the overrun flag (status bit 1), keeps the unread byte in the data register and discards the new byte.
- R7: A byte strobe with the noise indication high sets the noise flag (status bit 2). The noise flag clears through the same read sequence as the other flags.
- R8: irq_o is the OR of full AND full_ie_i, overrun AND ovr_ie_i, and noise AND noise_ie_i.
- R9: A byte strobe in the same cycle as a clearing data read is accepted. The read returns the old byte, the full flag stays set and the data register takes the new byte.
- R10: A read strobe (sel_i and rd_i high) with addr_i = 0 selects status and addr_i = 1 selects data. rdata_o shows the selected register one cycle after the strobe. Status bits 3 and up read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | One-cycle strobe for a completed byte |
| rx_data_i | input | DATA_W | Completed byte |
| rx_noise_i | input | 1 | Noise seen while receiving this byte |
| sel_i | input | 1 | Register select |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 1 | 0 = status, 1 = data |
| full_ie_i | input | 1 | Interrupt enable for the full flag |
| ovr_ie_i | input | 1 | Interrupt enable for the overrun flag |
| noise_ie_i | input | 1 | Interrupt enable for the noise flag |
| rdata_o | output | DATA_W | Read data, registered |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things:
- a byte strobe always leaves the full flag set;
- the full flag falls only on an armed data read;
- overrun rises only when a byte meets a full register, and the data register stays stable in that case;
- a flag that rose after the snapshot survives the data read.

Only the bench scenarios can show the following:
- which byte a read sequence actually returns in the delayed-clear case;
- that an unarmed data read leaves the flags alone;
- the same-cycle byte-and-clear case;
- the interrupt combination under each enable.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;
  typedef struct packed {
    logic noise;  // bit 2
    logic ovr;    // bit 1
    logic full;   // bit 0
  } rx_flags_t;

  localparam int unsigned FLAG_W = $bits(rx_flags_t);

  typedef enum logic {
    REG_STAT = 1'b0,
    REG_DATA = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/rx_data_hold.sv
module rx_data_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_q <= '0;
    else if (load_i) data_q <= din_i;
  end

  assign dout_o = data_q;
endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank
  import rx_flag_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      byte_i,
  input  logic      noise_i,
  input  logic      stat_rd_i,
  input  logic      data_rd_i,
  output logic      accept_o,
  output rx_flags_t flags_o
);
  rx_flags_t flags_q, snap_q, clr;
  logic      armed_q;

  // only flags captured by the arming status read may be cleared
  assign clr      = (data_rd_i && armed_q) ? snap_q : '0;
  assign accept_o = byte_i && (!flags_q.full || clr.full);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      snap_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      flags_q.full  <= (flags_q.full  & ~clr.full)  | accept_o;
      flags_q.ovr   <= (flags_q.ovr   & ~clr.ovr)   | (byte_i & ~accept_o);
      flags_q.noise <= (flags_q.noise & ~clr.noise) | (byte_i & noise_i);
      if (stat_rd_i) begin
        snap_q  <= flags_q;
        armed_q <= 1'b1;
      end else if (data_rd_i) begin
        armed_q <= 1'b0;
      end
    end
  end

  assign flags_o = flags_q;

  AST_FULL_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_i |=> flags_q.full); // R2
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_q.full) |-> $past(data_rd_i && armed_q)); // R3
  AST_LATE_OVR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && armed_q && !snap_q.ovr && flags_q.ovr) |=> flags_q.ovr); // R5
  AST_OVR_FROM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_q.ovr) |-> $past(flags_q.full && byte_i)); // R6
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import rx_flag_pkg::*;
(
  input  rx_flags_t          flags_i,
  input  logic [FLAG_W-1:0]  ie_i,
  output logic               irq_o
);
  assign irq_o = |(flags_i & ie_i);
endmodule

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import rx_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_noise_i,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              addr_i,
  input  logic              full_ie_i,
  input  logic              ovr_ie_i,
  input  logic              noise_ie_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned PAD_W = DATA_W - FLAG_W;

  logic              acc, stat_rd, data_rd;
  rx_flags_t         flags;
  logic [DATA_W-1:0] data_q, rdata_q;

  assign stat_rd = sel_i && rd_i && (reg_sel_e'(addr_i) == REG_STAT);
  assign data_rd = sel_i && rd_i && (reg_sel_e'(addr_i) == REG_DATA);

  rx_flag_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_i    (rx_valid_i),
    .noise_i   (rx_noise_i),
    .stat_rd_i (stat_rd),
    .data_rd_i (data_rd),
    .accept_o  (acc),
    .flags_o   (flags)
  );

  rx_data_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (acc),
    .din_i  (rx_data_i),
    .dout_o (data_q)
  );

  rx_irq_gen u_irq (
    .flags_i (flags),
    .ie_i    ({noise_ie_i, ovr_ie_i, full_ie_i}),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (data_rd) rdata_q <= data_q;
    else if (stat_rd) rdata_q <= {{PAD_W{1'b0}}, flags};
  end

  assign rdata_o = rdata_q;

  AST_DATA_KEPT_ON_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags.full && rx_valid_i && !data_rd) |=> $stable(data_q)); // R6
  AST_STAT_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |=> (rdata_o[DATA_W-1:FLAG_W] == '0)); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags != '0)); // R8
endmodule

// File: tb/rx_flag_ctrl_tb_top.sv
module rx_flag_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_noise = 1'b0;
  logic [7:0] rx_data = '0;
  logic       sel = 1'b0, rd = 1'b0, addr = 1'b0;
  logic       f_ie = 1'b0, o_ie = 1'b0, n_ie = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic       m_full = 0, m_ovr = 0, m_noise = 0, m_armed = 0;
  logic [2:0] m_snap = '0;
  logic [7:0] m_data = '0;
  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  rx_flag_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_noise_i(rx_noise), .sel_i(sel), .rd_i(rd), .addr_i(addr),
    .full_ie_i(f_ie), .ovr_ie_i(o_ie), .noise_ie_i(n_ie),
    .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic m_irq();
    return (m_full & f_ie) | (m_ovr & o_ie) | (m_noise & n_ie);
  endfunction

  // one cycle of stimulus, model advanced to the state after the edge
  task automatic cycle(input logic bv, input logic [7:0] d, input logic n,
                       input logic rv, input logic a, input string tag);
    logic [2:0] clr;
    logic acc;
    @(negedge clk);
    rx_valid = bv; rx_data = d; rx_noise = n; sel = rv; rd = rv; addr = a;
    if (rv) begin
      q_exp.push_back(a ? m_data : {5'b0, m_noise, m_ovr, m_full});
      q_tag.push_back(tag);
    end
    clr = (rv && a && m_armed) ? m_snap : 3'b0;
    acc = bv && (!m_full || clr[0]);
    if (rv && !a) begin m_snap = {m_noise, m_ovr, m_full}; m_armed = 1; end
    else if (rv && a) m_armed = 0;
    m_full  = (m_full  & ~clr[0]) | acc;
    m_ovr   = (m_ovr   & ~clr[1]) | (bv & ~acc);
    m_noise = (m_noise & ~clr[2]) | (bv & n);
    if (acc) m_data = d;
    @(posedge clk);
    #1;
    rx_valid = 0; sel = 0; rd = 0;
  endtask

  task automatic rx(input logic [7:0] d, input logic n, input string tag);
    cycle(1'b1, d, n, 1'b0, 1'b0, tag);
  endtask
  task automatic rs(input string tag); cycle(1'b0, 8'h0, 1'b0, 1'b1, 1'b0, tag); endtask
  task automatic rdd(input string tag); cycle(1'b0, 8'h0, 1'b0, 1'b1, 1'b1, tag); endtask
  task automatic set_ie(input logic f, input logic o, input logic n);
    @(negedge clk); f_ie = f; o_ie = o; n_ie = n;
  endtask

  // monitor: read results and interrupt line
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n) begin
        if (q_exp.size() > 0) begin
          logic [7:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          checks++;
          if (rdata !== e) begin
            errors++;
            $display("FAIL %s rdata actual %02h expected %02h", t, rdata, e);
          end
        end
        checks++;
        if (irq !== m_irq()) begin
          errors++;
          $display("FAIL R8 irq actual %0b expected %0b", irq, m_irq());
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (irq !== 1'b0 || rdata !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset outputs actual %0b/%02h expected 0/00", irq, rdata);
    end
    rst_n = 1;
    rs("R1"); rdd("R1");
    // basic receive and clear
    rx(8'hA5, 0, "R2"); rs("R2 R10"); rdd("R3"); rs("R3");
    // unarmed data read
    rx(8'h3C, 0, "R4"); rdd("R4"); rdd("R4"); rs("R4"); rdd("R3"); rs("R3");
    // delayed clear, overrun
    rx(8'h11, 0, "R6"); rs("R5"); rx(8'h22, 0, "R6"); rdd("R6");
    rs("R5"); rdd("R6"); rs("R5");
    // noise
    rx(8'h5A, 1, "R7"); rs("R7"); rdd("R7"); rs("R7");
    // interrupt enables
    set_ie(1, 0, 0); rx(8'h01, 0, "R8"); cycle(0, 0, 0, 0, 0, "R8");
    set_ie(0, 0, 0); cycle(0, 0, 0, 0, 0, "R8");
    set_ie(0, 1, 0); rx(8'h02, 1, "R8"); cycle(0, 0, 0, 0, 0, "R8");
    set_ie(0, 0, 1); cycle(0, 0, 0, 0, 0, "R8");
    set_ie(1, 1, 1); rs("R8"); rdd("R8"); rs("R8");
    set_ie(0, 0, 0);
    // byte in same cycle as clearing read
    rx(8'h77, 0, "R9"); rs("R9"); cycle(1, 8'h88, 0, 1, 1, "R9");
    rs("R9"); rdd("R9"); rs("R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule